// File: doc/BRIEF.md
# Two-Phase Test Response Comparator

This block sits beside a sequential device under test and judges its responses one vector per clock. A run begins with a start pulse. It then passes through an initialization phase, which drives the device into a known state. After that comes the test phase proper. During initialization the device's responses cannot be predicted, so the comparator discards them. During the test phase it compares each observed vector with an expected vector that is supplied alongside it.

Every expected bit carries a care bit. A bit whose care bit is set is definite: a difference there is a hard detection. A bit whose care bit is clear is unknown: a difference there only raises a potential-detection flag. The comparator records the position of the first hard-failing test vector and holds it. A last-vector marker closes the run with a one-cycle done pulse. Any return to the initialization phase after test vectors have been seen, without a new start pulse, is flagged as a protocol error.

Top module: `resp_cmp_top`

## Requirements
- R1: After reset, fail, first_idx, maybe_hit, done and seq_err are all 0.
- R2: A valid vector with phase_test=0 (initialization phase) never sets fail or maybe_hit, whatever its bits, and does not advance the test vector index.
- R3: In a valid vector with phase_test=1, any bit with care=1 where observed differs from expected sets fail in the cycle after that vector.
- R4: first_idx equals the zero-based count of valid test-phase vectors that came before the first hard-failing one. Cycles with vec_valid=0 do not count. Later failing vectors change neither fail nor first_idx.
- R5: A test-phase difference only on bits with care=0 sets maybe_hit (sticky) and leaves fail unchanged.
- R6: A valid vector with last_vec=1 makes done high for exactly the next cycle. In that cycle, fail already reflects every vector of the run, including the last one.
- R7: A start pulse clears fail, first_idx, maybe_hit, seq_err and the vector index. A vector presented in the same cycle as start is ignored.
- R8: A valid initialization-phase vector that follows any valid test-phase vector since the last start sets seq_err, which stays high until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a new run and clears the recorded results |
| vec_valid | input | 1 | A response vector is present this cycle |
| phase_test | input | 1 | 1 = test phase, 0 = initialization phase |
| last_vec | input | 1 | Marks the final vector of the run |
| obs_vec | input | W | Observed response of the device |
| exp_vec | input | W | Expected response |
| care_vec | input | W | 1 = expected bit is definite, 0 = unknown |
| fail | output | 1 | Sticky hard-detection flag |
| first_idx | output | IW | Test-phase index of the first hard-failing vector |
| maybe_hit | output | 1 | Sticky potential-detection flag |
| done | output | 1 | One-cycle end-of-run pulse |
| seq_err | output | 1 | Sticky phase protocol error |

## Verification
On every cycle, the embedded properties check four things. The fail and error flags stay set until start. The recorded index stays frozen once fail is set. The index never moves on idle cycles. Detection flags rise only after a valid test-phase vector.

The bench's scenarios are what show the correct value of the captured index. They also show that initialization responses are fully discarded, that unknown bits separate potential detection from hard detection, that a vector presented together with start is dropped, and that done lines up with the final verdict.

// File: rtl/resp_cmp_pkg.sv
package resp_cmp_pkg;
  localparam logic PH_INIT = 1'b0;
  localparam logic PH_TEST = 1'b1;
endpackage

// File: rtl/resp_cmp_diff.sv
module resp_cmp_diff #(
  parameter int W = 8
) (
  input  logic [W-1:0] obs_vec,
  input  logic [W-1:0] exp_vec,
  input  logic [W-1:0] care_vec,
  output logic         hard_mis,
  output logic         soft_mis
);
  logic [W-1:0] hard_bits;
  logic [W-1:0] soft_bits;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic differs;
    assign differs      = obs_vec[b] ^ exp_vec[b];
    assign hard_bits[b] = differs & care_vec[b];
    assign soft_bits[b] = differs & ~care_vec[b];
  end

  assign hard_mis = |hard_bits;
  assign soft_mis = |soft_bits;
endmodule

// File: rtl/resp_cmp_index.sv
module resp_cmp_index #(
  parameter int IW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  output logic [IW-1:0] cur_idx
);
  localparam logic [IW-1:0] IDX_MAX = {IW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clear)
      cur_idx <= '0;
    else if (step && cur_idx != IDX_MAX)
      cur_idx <= cur_idx + 1'b1;
  end

  // R4
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!step && !clear) |=> $stable(cur_idx));
endmodule

// File: rtl/resp_cmp_track.sv
module resp_cmp_track #(
  parameter int IW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          vec_valid,
  input  logic          is_test,
  input  logic          last_vec,
  input  logic          hard_mis,
  input  logic          soft_mis,
  input  logic [IW-1:0] cur_idx,
  output logic          fail,
  output logic [IW-1:0] first_idx,
  output logic          maybe_hit,
  output logic          done,
  output logic          seq_err
);
  logic seen_test;
  logic take_test;
  logic take_init;

  assign take_test = vec_valid && is_test && !start;
  assign take_init = vec_valid && !is_test && !start;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      fail      <= 1'b0;
      first_idx <= '0;
      maybe_hit <= 1'b0;
      seq_err   <= 1'b0;
      seen_test <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= vec_valid && last_vec;
      if (take_test) begin
        seen_test <= 1'b1;
        if (hard_mis && !fail) begin
          fail      <= 1'b1;
          first_idx <= cur_idx;
        end
        if (soft_mis)
          maybe_hit <= 1'b1;
      end
      if (take_init && seen_test)
        seq_err <= 1'b1;
    end
  end

  // R4
  idx_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (fail && !start) |=> $stable(first_idx));
  // R3
  fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (fail && !start) |=> fail);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_err && !start) |=> seq_err);
  // R2
  fail_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> $past(vec_valid && is_test));
  // R5
  maybe_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(maybe_hit) |-> $past(vec_valid && is_test));
endmodule

// File: rtl/resp_cmp_top.sv
module resp_cmp_top #(
  parameter int W  = 8,
  parameter int IW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          vec_valid,
  input  logic          phase_test,
  input  logic          last_vec,
  input  logic [W-1:0]  obs_vec,
  input  logic [W-1:0]  exp_vec,
  input  logic [W-1:0]  care_vec,
  output logic          fail,
  output logic [IW-1:0] first_idx,
  output logic          maybe_hit,
  output logic          done,
  output logic          seq_err
);
  import resp_cmp_pkg::*;

  logic          is_test;
  logic          hard_mis;
  logic          soft_mis;
  logic [IW-1:0] cur_idx;

  assign is_test = (phase_test == PH_TEST);

  resp_cmp_diff #(.W(W)) u_diff (
    .obs_vec(obs_vec), .exp_vec(exp_vec), .care_vec(care_vec),
    .hard_mis(hard_mis), .soft_mis(soft_mis)
  );

  resp_cmp_index #(.IW(IW)) u_index (
    .clk(clk), .rst(rst), .clear(start),
    .step(vec_valid && is_test && !start), .cur_idx(cur_idx)
  );

  resp_cmp_track #(.IW(IW)) u_track (
    .clk(clk), .rst(rst), .start(start), .vec_valid(vec_valid),
    .is_test(is_test), .last_vec(last_vec), .hard_mis(hard_mis),
    .soft_mis(soft_mis), .cur_idx(cur_idx), .fail(fail),
    .first_idx(first_idx), .maybe_hit(maybe_hit), .done(done),
    .seq_err(seq_err)
  );
endmodule

// File: tb/resp_cmp_top_test.sv
module resp_cmp_top_test;
  localparam int W  = 8;
  localparam int IW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          vec_valid = 1'b0;
  logic          phase_test = 1'b0;
  logic          last_vec = 1'b0;
  logic [W-1:0]  obs_vec = '0;
  logic [W-1:0]  exp_vec = '0;
  logic [W-1:0]  care_vec = '0;
  logic          fail;
  logic [IW-1:0] first_idx;
  logic          maybe_hit;
  logic          done;
  logic          seq_err;

  always #4 clk = ~clk;

  resp_cmp_top #(.W(W), .IW(IW)) uut (
    .clk(clk), .rst(rst), .start(start), .vec_valid(vec_valid),
    .phase_test(phase_test), .last_vec(last_vec), .obs_vec(obs_vec),
    .exp_vec(exp_vec), .care_vec(care_vec), .fail(fail),
    .first_idx(first_idx), .maybe_hit(maybe_hit), .done(done),
    .seq_err(seq_err)
  );

  typedef struct {
    logic          f;
    logic [IW-1:0] i;
    logic          m;
    logic          d;
    logic          e;
    string         tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_bad = 0;

  logic          m_f = 0, m_m = 0, m_e = 0, m_seen = 0;
  logic [IW-1:0] m_i = '0, m_cnt = '0;

  task automatic step(input logic st, input logic v, input logic ph,
                      input logic lst, input logic [W-1:0] o,
                      input logic [W-1:0] e, input logic [W-1:0] c,
                      input string tag);
    logic d;
    exp_t x;
    @(negedge clk);
    start = st; vec_valid = v; phase_test = ph; last_vec = lst;
    obs_vec = o; exp_vec = e; care_vec = c;
    d = 1'b0;
    if (st) begin
      m_f = 0; m_i = '0; m_m = 0; m_e = 0; m_seen = 0; m_cnt = '0;
    end else if (v) begin
      if (ph) begin
        if ((|((o ^ e) & c)) && !m_f) begin m_f = 1; m_i = m_cnt; end
        if (|((o ^ e) & ~c)) m_m = 1;
        if (m_cnt != {IW{1'b1}}) m_cnt = m_cnt + 1'b1;
        m_seen = 1;
      end else if (m_seen) begin
        m_e = 1;
      end
      d = lst;
    end
    @(posedge clk);
    x.f = m_f; x.i = m_i; x.m = m_m; x.d = d; x.e = m_e; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 1, 0, 8'h00, 8'hFF, 8'hFF, tag);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      n_chk++;
      if (fail !== x.f || first_idx !== x.i || maybe_hit !== x.m ||
          done !== x.d || seq_err !== x.e) begin
        n_bad++;
        $display("FAIL %s: got f=%0b i=%0d m=%0b d=%0b e=%0b exp f=%0b i=%0d m=%0b d=%0b e=%0b",
                 x.tag, fail, first_idx, maybe_hit, done, seq_err,
                 x.f, x.i, x.m, x.d, x.e);
      end
    end
  end

  initial begin
    exp_t x;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    n_chk++;
    if (fail !== 0 || first_idx !== 0 || maybe_hit !== 0 || done !== 0 || seq_err !== 0) begin
      n_bad++;
      $display("FAIL R1: got f=%0b i=%0d m=%0b d=%0b e=%0b exp all 0",
               fail, first_idx, maybe_hit, done, seq_err);
    end
    // run 1: init garbage, then test phase with a hard fail at index 3
    step(1, 0, 0, 0, 8'h00, 8'h00, 8'h00, "R7 start");
    step(0, 1, 0, 0, 8'hA5, 8'h5A, 8'hFF, "R2 init mismatch");
    step(0, 1, 0, 0, 8'hFF, 8'h00, 8'h0F, "R2 init mismatch");
    step(0, 1, 1, 0, 8'h3C, 8'h3C, 8'hFF, "R3 match idx0");
    idle("R4 idle");
    step(0, 1, 1, 0, 8'h11, 8'h11, 8'hFF, "R3 match idx1");
    step(0, 1, 1, 0, 8'h81, 8'h80, 8'hFE, "R5 soft idx2");
    idle("R4 idle");
    step(0, 1, 1, 0, 8'h40, 8'h00, 8'hC0, "R3 hard idx3");
    step(0, 1, 1, 0, 8'h00, 8'hFF, 8'hFF, "R4 later fail idx4");
    step(0, 1, 1, 1, 8'h00, 8'h00, 8'hFF, "R6 last");
    idle("R6 done drop");
    // run 2: start with a vector, soft-only, fail on the last vector
    step(1, 1, 1, 0, 8'hFF, 8'h00, 8'hFF, "R7 start vec ignored");
    step(0, 1, 1, 0, 8'h02, 8'h00, 8'hFD, "R5 soft only");
    step(0, 1, 1, 0, 8'h10, 8'h10, 8'hFF, "R5 match");
    step(0, 1, 1, 1, 8'h01, 8'h00, 8'h01, "R6 fail on last idx2");
    idle("R6 done drop");
    // run 3: clean pass with a protocol error
    step(1, 0, 0, 0, 8'h00, 8'h00, 8'h00, "R7 start");
    step(0, 1, 0, 0, 8'h00, 8'hFF, 8'hFF, "R2 init");
    step(0, 1, 1, 0, 8'h77, 8'h77, 8'hFF, "R3 match");
    idle("R8 idle");
    step(0, 1, 0, 0, 8'h00, 8'h00, 8'hFF, "R8 back to init");
    step(0, 1, 1, 1, 8'h55, 8'h55, 8'hFF, "R6 clean last");
    idle("R8 err held");
    step(1, 0, 0, 0, 8'h00, 8'h00, 8'h00, "R7 clear err");
    idle("R7 cleared");
    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule